// File: doc/BRIEF.md
# Lane Selector and Packet Framer

This block takes a bank of sample lanes, each a 32-bit word with its own valid strobe, and feeds a smaller set of output stream lanes. Each output lane has a select field that picks the input lane it follows. A start pulse arms every enabled output lane at the same time. Each armed lane then collects a programmed number of valid samples from its chosen source. It sends them downstream on a ready/valid/last handshake and cuts them into transactions whose size is capped by a power-of-two parameter.

When header mode is on at start, a lane first sends a short header. The header is a marker word holding the lane number and an invalid flag taken from the freeze input, then the 64-bit timestamp captured at start, then the packet length. A small FIFO in each lane absorbs the samples that arrive while the downstream side stalls. A one-cycle done pulse reports that every armed lane has finished.

Top module: `lane_pkt_framer`

## Requirements
- R1: Each output lane carries the samples of the input lane chosen by its select field at start, in arrival order, and only from cycles where that input's valid bit is 1.
- R2: A start pulse that is accepted at a clock edge makes each enabled lane collect exactly pkt_len stored samples (pkt_len of at least 1). Collection begins at the next edge. The lane then emits those words and nothing more.
- R3: In the data phase, out_last is 1 on every 2^FRAME_BITS-th data word of a packet and on the packet's final word.
- R4: With hdr_en at 1 at start, the lane first emits four header words, in this order: marker, timestamp bits 31:0, timestamp bits 63:32, and pkt_len zero-extended. The fourth header word carries out_last.
- R5: The marker word is {8'hD5, 7'b0, invalid, 8'h00, lane number[7:0]}. The invalid bit is at position 16 and equals freeze as sampled at start.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last of that lane hold their values into the next cycle.
- R7: A valid sample that arrives while a collecting lane's FIFO is full is dropped and does not count toward pkt_len. It sets that lane's overflow bit, which stays at 1 until reset.
- R8: done is 1 for exactly one cycle: the cycle after the edge at which the last armed lane hands off its final word.
- R9: A start pulse that arrives while busy is 1 has no effect on any lane.
- R10: After reset, out_valid, busy, done and overflow are all 0. A lane whose lane_en bit was 0 at start never raises out_valid.
- R11: Header timestamp words carry the value of timestamp at the start edge. Later changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | N_IN*32 | Input sample words, lane i at bits [32*i+31:32*i] |
| in_valid | input | N_IN | Per-input sample valid |
| sel | input | N_OUT*SEL_W | Per-output source index |
| lane_en | input | N_OUT | Output lanes armed by start |
| pkt_len | input | LEN_W | Packet length in data words |
| hdr_en | input | 1 | Emit header before data |
| freeze | input | 1 | Mark packet invalid in header |
| timestamp | input | 64 | Time value captured at start |
| start | input | 1 | Start pulse |
| out_data | output | N_OUT*32 | Output stream words |
| out_valid | output | N_OUT | Output word valid |
| out_last | output | N_OUT | Transaction end marker |
| out_ready | input | N_OUT | Downstream ready per lane |
| overflow | output | N_OUT | Sticky FIFO overflow per lane |
| busy | output | 1 | Any lane in a packet |
| done | output | 1 | One-cycle packet completion pulse |

## Verification
The bench sets FRAME_BITS to 2, so transactions are four words long. A ten-word packet then splits into 4+4+2, and the interior last markers show up after a few cycles. FIFO_DEPTH is set to 4, so a short downstream stall with valid samples on every cycle is enough to overflow and drop samples. All sixteen inputs and four outputs are kept, so the select fields can reach index 15 and a lane can be left disabled.

// File: rtl/lane_framer_pkg.sv
package lane_framer_pkg;
    localparam int WORD_W    = 32;
    localparam int HDR_WORDS = 4;
    localparam logic [7:0] HDR_TAG = 8'hD5;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_HDR,
        CH_DATA
    } ch_state_e;

    typedef struct packed {
        logic [63:0] ts;
        logic        inval;
    } pkt_meta_t;

    function automatic logic [WORD_W-1:0] hdr_word(
        input logic [1:0]        idx,
        input logic [7:0]        lane,
        input pkt_meta_t         meta,
        input logic [WORD_W-1:0] len
    );
        case (idx)
            2'd0:    hdr_word = {HDR_TAG, 7'd0, meta.inval, 8'd0, lane};
            2'd1:    hdr_word = meta.ts[31:0];
            2'd2:    hdr_word = meta.ts[63:32];
            default: hdr_word = len;
        endcase
    endfunction
endpackage

// File: rtl/lane_src_mux.sv
module lane_src_mux #(
    parameter int N_IN  = 16,
    parameter int SEL_W = 4
) (
    input  logic [N_IN*32-1:0] in_data,
    input  logic [N_IN-1:0]    in_valid,
    input  logic [SEL_W-1:0]   sel,
    output logic [31:0]        data,
    output logic               valid
);
    always_comb begin
        data  = '0;
        valid = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == SEL_W'(i)) begin
                data  = in_data[i*32 +: 32];
                valid = in_valid[i];
            end
        end
    end
endmodule

// File: rtl/lane_word_fifo.sv
module lane_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/lane_framer_chan.sv
module lane_framer_chan
    import lane_framer_pkg::*;
#(
    parameter int LANE_ID    = 0,
    parameter int SEL_W      = 4,
    parameter int FRAME_BITS = 10,
    parameter int FIFO_DEPTH = 16,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             hdr_en,
    input  logic             freeze,
    input  logic [63:0]      timestamp,
    input  logic [LEN_W-1:0] pkt_len,
    output logic [SEL_W-1:0] sel_q,
    input  logic [31:0]      s_data,
    input  logic             s_valid,
    output logic [31:0]      out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready,
    output logic             overflow,
    output logic             active
);
    ch_state_e            st;
    pkt_meta_t            meta;
    logic [LEN_W-1:0]     len_q, cap_cnt, emit_cnt;
    logic [FRAME_BITS-1:0] tx_cnt;
    logic [1:0]           hdr_idx;
    logic                 f_full, f_empty, f_push, f_pop, cap_on, hs, data_last;
    logic [31:0]          f_dout;

    assign active    = (st != CH_IDLE);
    assign cap_on    = active && (cap_cnt != len_q);
    assign f_push    = cap_on && s_valid && !f_full;
    assign out_valid = (st == CH_HDR) || ((st == CH_DATA) && !f_empty);
    assign hs        = out_valid && out_ready;
    assign f_pop     = (st == CH_DATA) && hs;
    assign data_last = (emit_cnt == len_q - LEN_W'(1)) || (&tx_cnt);
    assign out_last  = (st == CH_HDR) ? (hdr_idx == 2'd3) : data_last;
    assign out_data  = (st == CH_HDR)
                     ? hdr_word(hdr_idx, 8'(LANE_ID), meta, 32'(len_q))
                     : f_dout;

    lane_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst(rst),
        .push(f_push), .din(s_data),
        .pop(f_pop), .dout(f_dout),
        .full(f_full), .empty(f_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CH_IDLE;
            meta     <= '0;
            len_q    <= '0;
            sel_q    <= '0;
            cap_cnt  <= '0;
            emit_cnt <= '0;
            tx_cnt   <= '0;
            hdr_idx  <= '0;
            overflow <= 1'b0;
        end else begin
            if (cap_on && s_valid && f_full) overflow <= 1'b1;
            if (f_push) cap_cnt <= cap_cnt + 1'b1;
            case (st)
                CH_IDLE: begin
                    if (go) begin
                        st         <= hdr_en ? CH_HDR : CH_DATA;
                        meta.ts    <= timestamp;
                        meta.inval <= freeze;
                        len_q      <= pkt_len;
                        sel_q      <= sel_in;
                        cap_cnt    <= '0;
                        emit_cnt   <= '0;
                        tx_cnt     <= '0;
                        hdr_idx    <= '0;
                    end
                end
                CH_HDR: begin
                    if (hs) begin
                        hdr_idx <= hdr_idx + 1'b1;
                        if (hdr_idx == 2'd3) st <= CH_DATA;
                    end
                end
                default: begin
                    if (hs) begin
                        emit_cnt <= emit_cnt + 1'b1;
                        tx_cnt   <= tx_cnt + 1'b1;
                        if (emit_cnt == len_q - LEN_W'(1)) st <= CH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lane_pkt_framer.sv
module lane_pkt_framer
    import lane_framer_pkg::*;
#(
    parameter int N_IN       = 16,
    parameter int N_OUT      = 4,
    parameter int FRAME_BITS = 10,
    parameter int FIFO_DEPTH = 16,
    parameter int LEN_W      = 16,
    localparam int SEL_W     = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN*32-1:0]     in_data,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [N_OUT*SEL_W-1:0] sel,
    input  logic [N_OUT-1:0]       lane_en,
    input  logic [LEN_W-1:0]       pkt_len,
    input  logic                   hdr_en,
    input  logic                   freeze,
    input  logic [63:0]            timestamp,
    input  logic                   start,
    output logic [N_OUT*32-1:0]    out_data,
    output logic [N_OUT-1:0]       out_valid,
    output logic [N_OUT-1:0]       out_last,
    input  logic [N_OUT-1:0]       out_ready,
    output logic [N_OUT-1:0]       overflow,
    output logic                   busy,
    output logic                   done
);
    logic [N_OUT-1:0] lane_act;
    logic             busy_q;
    logic             start_ok;

    assign busy     = |lane_act;
    assign start_ok = start && !busy;
    assign done     = busy_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        logic [SEL_W-1:0] sel_q;
        logic [31:0]      s_data;
        logic             s_valid;

        lane_src_mux #(.N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
            .in_data(in_data), .in_valid(in_valid), .sel(sel_q),
            .data(s_data), .valid(s_valid)
        );

        lane_framer_chan #(
            .LANE_ID(g), .SEL_W(SEL_W), .FRAME_BITS(FRAME_BITS),
            .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)
        ) u_chan (
            .clk(clk), .rst(rst),
            .go(start_ok && lane_en[g]),
            .sel_in(sel[g*SEL_W +: SEL_W]),
            .hdr_en(hdr_en), .freeze(freeze), .timestamp(timestamp),
            .pkt_len(pkt_len), .sel_q(sel_q),
            .s_data(s_data), .s_valid(s_valid),
            .out_data(out_data[g*32 +: 32]), .out_valid(out_valid[g]),
            .out_last(out_last[g]), .out_ready(out_ready[g]),
            .overflow(overflow[g]), .active(lane_act[g])
        );
    end
endmodule

// File: rtl/lane_pkt_framer_chk.sv
module lane_pkt_framer_chk #(
    parameter int N_OUT = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [N_OUT*32-1:0] out_data,
    input logic [N_OUT-1:0]    out_valid,
    input logic [N_OUT-1:0]    out_last,
    input logic [N_OUT-1:0]    out_ready,
    input logic [N_OUT-1:0]    overflow
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && !out_ready[g]) |=>
                (out_valid[g] && $stable(out_data[g*32 +: 32]) && $stable(out_last[g])));

        assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (rst)
            overflow[g] |=> overflow[g]);

        assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
            out_valid[g] |-> busy);
    end
endmodule

bind lane_pkt_framer lane_pkt_framer_chk #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready), .overflow(overflow)
);

// File: tb/lane_pkt_framer_tb.sv
module lane_pkt_framer_tb;
    localparam int NI = 16, NO = 4, FB = 2, FD = 4, LW = 8, SW = 4;
    localparam int TXW = 1 << FB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NI*32-1:0] in_data = '0;
    logic [NI-1:0]    in_valid = '0;
    logic [NO*SW-1:0] sel = '0;
    logic [NO-1:0]    lane_en = '0, out_ready = '0;
    logic [LW-1:0]    pkt_len = '0;
    logic             hdr_en = 1'b0, freeze = 1'b0, start = 1'b0;
    logic [63:0]      ts = '0;
    wire  [NO*32-1:0] out_data;
    wire  [NO-1:0]    out_valid, out_last, overflow;
    wire              busy, done;

    lane_pkt_framer #(.N_IN(NI), .N_OUT(NO), .FRAME_BITS(FB), .FIFO_DEPTH(FD), .LEN_W(LW)) u_dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .sel(sel),
        .lane_en(lane_en), .pkt_len(pkt_len), .hdr_en(hdr_en), .freeze(freeze),
        .timestamp(ts), .start(start), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .out_ready(out_ready), .overflow(overflow),
        .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_act [NO];
    int          m_hidx[NO];   // -1 means data phase
    int          m_cap [NO], m_emit[NO], m_tx[NO], m_len[NO], m_sel[NO];
    logic [63:0] m_ts  [NO];
    bit          m_frz [NO], m_ovf[NO], m_stall[NO];
    logic [31:0] m_q   [NO][$];
    bit          m_busyq;
    bit          t_bp, t_v, t_hs, t_act;
    int          t_qs;

    function automatic bit m_busy();
        bit b = 0;
        for (int l = 0; l < NO; l++) b |= m_act[l];
        return b;
    endfunction

    function automatic bit exp_valid(int l);
        return m_act[l] && (m_hidx[l] >= 0 || m_q[l].size() > 0);
    endfunction

    function automatic bit exp_last(int l);
        if (m_hidx[l] >= 0) return m_hidx[l] == 3;
        return (m_emit[l] + 1 == m_len[l]) || (m_tx[l] == TXW - 1);
    endfunction

    function automatic logic [31:0] exp_word(int l);
        case (m_hidx[l])
            0:  return 32'hD500_0000 | (32'(m_frz[l]) << 16) | 32'(l);
            1:  return m_ts[l][31:0];
            2:  return m_ts[l][63:32];
            3:  return 32'(m_len[l]);
            default: return m_q[l][0];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NO; l++) begin
                m_act[l] = 0; m_hidx[l] = -1; m_ovf[l] = 0; m_stall[l] = 0;
                m_q[l].delete();
            end
            m_busyq = 0;
        end else begin
            t_bp = m_busy();
            for (int l = 0; l < NO; l++) begin
                t_v   = exp_valid(l);
                t_hs  = t_v && out_ready[l];
                t_qs  = m_q[l].size();
                t_act = m_act[l];
                m_stall[l] = t_v && !out_ready[l];
                if (t_act) begin
                    if (m_hidx[l] >= 0) begin
                        if (t_hs) begin
                            m_hidx[l]++;
                            if (m_hidx[l] == 4) m_hidx[l] = -1;
                        end
                    end else if (t_hs) begin
                        void'(m_q[l].pop_front());
                        m_emit[l]++;
                        m_tx[l] = (m_tx[l] + 1) % TXW;
                        if (m_emit[l] == m_len[l]) m_act[l] = 0;
                    end
                    if (m_cap[l] < m_len[l] && in_valid[m_sel[l]]) begin
                        if (t_qs < FD) begin
                            m_q[l].push_back(in_data[m_sel[l]*32 +: 32]);
                            m_cap[l]++;
                        end else begin
                            m_ovf[l] = 1;
                        end
                    end
                end
                if (start && !t_bp && lane_en[l]) begin
                    m_act[l] = 1; m_hidx[l] = hdr_en ? 0 : -1;
                    m_cap[l] = 0; m_emit[l] = 0; m_tx[l] = 0;
                    m_len[l] = int'(pkt_len); m_sel[l] = int'(sel[l*SW +: SW]);
                    m_ts[l] = ts; m_frz[l] = freeze;
                end
            end
            m_busyq = t_bp;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(busy == m_busy(), "R9 busy", 64'(busy), 64'(m_busy()));
            check(done == (m_busyq && !m_busy()), "R8 done", 64'(done), 64'(m_busyq && !m_busy()));
            for (int l = 0; l < NO; l++) begin
                string tag;
                bit ev;
                ev = exp_valid(l);
                check(overflow[l] == m_ovf[l], "R7 overflow", 64'(overflow[l]), 64'(m_ovf[l]));
                if (m_stall[l])           tag = "R6 stall";
                else if (!m_act[l])       tag = "R10 idle";
                else if (m_hidx[l] == 0)  tag = "R5 marker";
                else if (m_hidx[l] == 1 || m_hidx[l] == 2) tag = "R11 timestamp";
                else if (m_hidx[l] == 3)  tag = "R4 header";
                else                      tag = "R1 data";
                check(out_valid[l] == ev, {tag, " valid"}, 64'(out_valid[l]), 64'(ev));
                if (ev && out_valid[l]) begin
                    check(out_data[l*32 +: 32] == exp_word(l), {tag, " word"},
                          64'(out_data[l*32 +: 32]), 64'(exp_word(l)));
                    check(out_last[l] == exp_last(l), m_hidx[l] >= 0 ? "R4 hdr last" : "R3 last",
                          64'(out_last[l]), 64'(exp_last(l)));
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_pkt(input int len, input bit hdr, input bit frz, input logic [NO-1:0] en,
                           input logic [NO*SW-1:0] sels, input int vpct, input int rpct,
                           input int stall, input int poke_at);
        int hs_cnt[NO];
        int n;
        bit seen;
        @(negedge clk);
        pkt_len = LW'(len); hdr_en = hdr; freeze = frz; lane_en = en; sel = sels;
        ts = {$urandom, $urandom};
        start = 1'b1;
        for (int l = 0; l < NO; l++) hs_cnt[l] = 0;
        n = 0; seen = 0;
        while (!seen && n < 3000) begin
            @(negedge clk);
            if (n == 0) start = 1'b0;
            if (n == poke_at) begin
                // R9: restart attempt while busy, R11: timestamp change mid-packet
                start = 1'b1; ts = ~ts; freeze = ~freeze; lane_en = '1;
            end else if (n == poke_at + 1) begin
                start = 1'b0;
            end
            for (int i = 0; i < NI; i++) begin
                in_data[i*32 +: 32] = $urandom;
                in_valid[i] = ($urandom % 100) < vpct;
            end
            for (int l = 0; l < NO; l++) begin
                out_ready[l] = (n >= stall) && (($urandom % 100) < rpct);
                if (out_valid[l] && out_ready[l]) hs_cnt[l]++;
            end
            if (done) seen = 1;
            n++;
        end
        check(seen, "R8 done seen", 64'(seen), 64'(1));
        for (int l = 0; l < NO; l++) begin
            int expn;
            expn = en[l] ? len + (hdr ? 4 : 0) : 0;
            check(hs_cnt[l] == expn, "R2 word count", 64'(hs_cnt[l]), 64'(expn));
        end
        @(negedge clk);
        lane_en = '0; start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(out_valid == '0, "R10 reset valid", 64'(out_valid), 64'(0));
        check(busy == 1'b0, "R10 reset busy", 64'(busy), 64'(0));
        check(done == 1'b0, "R10 reset done", 64'(done), 64'(0));
        check(overflow == '0, "R10 reset overflow", 64'(overflow), 64'(0));
        // R1 R3: plain packet of 6 words (4+2), all lanes, full throughput
        run_pkt(6, 0, 0, 4'b1111, {4'd7, 4'd15, 4'd0, 4'd3}, 100, 100, 0, -5);
        // R4 R5 R9 R11: header, freeze, lane 2 disabled, random flow, mid-run poke
        run_pkt(9, 1, 1, 4'b1011, {4'd1, 4'd9, 4'd9, 4'd12}, 60, 70, 0, 4);
        // R7: stall with dense input forces drops
        run_pkt(10, 1, 0, 4'b0111, {4'd0, 4'd5, 4'd6, 4'd2}, 100, 100, 14, -5);
        check(overflow[0] == 1'b1, "R7 sticky set", 64'(overflow[0]), 64'(1));
        // R3: single-word packet and exact multiple of transaction size
        run_pkt(1, 1, 0, 4'b1000, {4'd14, 4'd0, 4'd0, 4'd0}, 50, 80, 0, -5);
        run_pkt(8, 0, 1, 4'b1111, {4'd4, 4'd4, 4'd8, 4'd11}, 40, 50, 0, 2);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule